// File: doc/BRIEF.md
# Segment-Test Corner Detector (12 of 16)

This block decides, once per clock, whether the centre pixel of a 7x7 intensity patch is a corner under the twelve-of-sixteen segment test. An upstream window buffer supplies all 49 pixels in parallel. The block compares the centre against the sixteen pixels that lie on a radius-3 discrete circle around it. A pixel counts as brighter when it exceeds the centre plus a programmable threshold, and as darker when it falls below the centre minus that threshold. The centre is a corner when at least twelve circularly adjacent circle pixels are all brighter, or all darker.

The contiguity search is done in parallel and needs no scanning. Each of the sixteen rotations of a twelve-bit window is matched against a run of ones, once in the brighter string and once in the darker string. The result is registered once, so the flag appears one cycle after the patch, together with a copy of the input strobe. A typical use is feeding the flag into a later feature stage alongside a descriptor that is computed on the same pixel.

Top module: `fast_seg_detect`

## Requirements
- R1: The patch is flattened row by row. Pixel (row r, column c), with r and c in 0..6 and row 0 at the top, occupies bits [(7*r+c)*8 +: 8] of `patch`, and the centre is (3,3).
- R2: Circle position k (0..15) runs clockwise from the pixel directly above the centre. As (dx,dy), with dy positive downwards, the positions are (0,-3),(1,-3),(2,-2),(3,-1),(3,0),(3,1),(2,2),(1,3),(0,3),(-1,3),(-2,2),(-3,1),(-3,0),(-3,-1),(-2,-2),(-1,-3). Runs are counted in this circular order only.
- R3: A circle pixel is brighter when it is strictly greater than min(centre+thresh, 255). A pixel equal to that limit is not brighter.
- R4: A circle pixel is darker when it is strictly less than max(centre-thresh, 0). A pixel equal to that limit is not darker.
- R5: The flag is set when 12 or more circularly consecutive circle pixels are all brighter, or are all darker. This includes runs that wrap from position 15 to position 0.
- R6: A run that mixes brighter and darker pixels never sets the flag.
- R7: A longest same-polarity run of 11 or fewer never sets the flag.
- R8: `corner_valid` equals `in_valid` delayed by exactly one clock. `corner_flag` gives the result for the patch presented one clock earlier.
- R9: `corner_flag` is 0 in any cycle where `corner_valid` is 0.
- R10: While `rst` is high at a clock edge, both outputs become 0 after that edge.
- R11: With all 16 circle pixels equal to the centre, the flag stays 0 for any threshold, including 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Patch on `patch` is valid this cycle |
| patch | input | 392 | 49 pixel intensities, 8 bits each, row-major |
| thresh | input | 8 | Intensity margin for the brighter and darker tests |
| corner_valid | output | 1 | Registered copy of `in_valid` |
| corner_flag | output | 1 | Registered corner decision, qualified by valid |

## Verification
The bench builds the block with its default parameters: 8-bit pixels and a run length of 12 on the sixteen-point circle. This brings the saturation corners within reach, for example centres at 0 and 255 with large thresholds. The bench places runs of lengths 10 through 16 at every start position, so wrapped runs and the 11-versus-12 boundary are both covered. Thresholds of 0, 1 and large values exercise the strict-inequality edges of the brighter and darker limits.

// File: rtl/fast_pkg.sv
package fast_pkg;
    localparam int PIX_W_DEF  = 8;
    localparam int SIDE       = 7;
    localparam int NPIX       = SIDE * SIDE;
    localparam int RADIUS     = 3;
    localparam int CENTRE_IDX = RADIUS * SIDE + RADIUS;
    localparam int RING_N     = 16;
    localparam int RUN_DEF    = 12;

    typedef struct packed {
        logic [RING_N-1:0] hi;
        logic [RING_N-1:0] lo;
    } ring_cmp_t;

    // circle offsets, clockwise from top; returned as flat patch index
    function automatic int ring_index(input int k);
        int dx;
        int dy;
        case (k)
            0:  begin dx =  0; dy = -3; end
            1:  begin dx =  1; dy = -3; end
            2:  begin dx =  2; dy = -2; end
            3:  begin dx =  3; dy = -1; end
            4:  begin dx =  3; dy =  0; end
            5:  begin dx =  3; dy =  1; end
            6:  begin dx =  2; dy =  2; end
            7:  begin dx =  1; dy =  3; end
            8:  begin dx =  0; dy =  3; end
            9:  begin dx = -1; dy =  3; end
            10: begin dx = -2; dy =  2; end
            11: begin dx = -3; dy =  1; end
            12: begin dx = -3; dy =  0; end
            13: begin dx = -3; dy = -1; end
            14: begin dx = -2; dy = -2; end
            default: begin dx = -1; dy = -3; end
        endcase
        return (RADIUS + dy) * SIDE + (RADIUS + dx);
    endfunction
endpackage

// File: rtl/fast_ring_cmp.sv
module fast_ring_cmp
    import fast_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF
) (
    input  logic [NPIX*PIX_W-1:0] patch,
    input  logic [PIX_W-1:0]      thresh,
    output ring_cmp_t             cmp
);
    localparam logic [PIX_W-1:0] PMAX = {PIX_W{1'b1}};

    logic [PIX_W-1:0] centre;
    logic [PIX_W:0]   up_sum;
    logic [PIX_W-1:0] hi_lim;
    logic [PIX_W-1:0] lo_lim;

    assign centre = patch[CENTRE_IDX*PIX_W +: PIX_W];

    always_comb begin
        up_sum = {1'b0, centre} + {1'b0, thresh};
        hi_lim = up_sum[PIX_W] ? PMAX : up_sum[PIX_W-1:0];
        lo_lim = (thresh > centre) ? '0 : (centre - thresh);
    end

    for (genvar k = 0; k < RING_N; k++) begin : g_ring
        localparam int IDX = ring_index(k);
        logic [PIX_W-1:0] pix;
        assign pix       = patch[IDX*PIX_W +: PIX_W];
        assign cmp.hi[k] = pix > hi_lim;
        assign cmp.lo[k] = pix < lo_lim;
    end
endmodule

// File: rtl/fast_run_det.sv
module fast_run_det #(
    parameter int RING_N  = 16,
    parameter int RUN_LEN = 12
) (
    input  logic [RING_N-1:0] bits,
    output logic              hit
);
    logic [RING_N-1:0] match;

    for (genvar s = 0; s < RING_N; s++) begin : g_start
        logic [RUN_LEN-1:0] win;
        for (genvar j = 0; j < RUN_LEN; j++) begin : g_bit
            assign win[j] = bits[(s + j) % RING_N];
        end
        assign match[s] = &win;
    end

    assign hit = |match;
endmodule

// File: rtl/fast_seg_detect.sv
module fast_seg_detect
    import fast_pkg::*;
#(
    parameter int PIX_W   = PIX_W_DEF,
    parameter int RUN_LEN = RUN_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [NPIX*PIX_W-1:0] patch,
    input  logic [PIX_W-1:0]      thresh,
    output logic                  corner_valid,
    output logic                  corner_flag
);
    ring_cmp_t         cmp;
    logic [RING_N-1:0] ring_hi;
    logic [RING_N-1:0] ring_lo;
    logic              hit_hi;
    logic              hit_lo;

    fast_ring_cmp #(.PIX_W(PIX_W)) cmp_i (
        .patch (patch),
        .thresh(thresh),
        .cmp   (cmp)
    );

    assign ring_hi = cmp.hi;
    assign ring_lo = cmp.lo;

    fast_run_det #(.RING_N(RING_N), .RUN_LEN(RUN_LEN)) run_hi_i (
        .bits(ring_hi),
        .hit (hit_hi)
    );

    fast_run_det #(.RING_N(RING_N), .RUN_LEN(RUN_LEN)) run_lo_i (
        .bits(ring_lo),
        .hit (hit_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            corner_valid <= 1'b0;
            corner_flag  <= 1'b0;
        end else begin
            corner_valid <= in_valid;
            corner_flag  <= in_valid & (hit_hi | hit_lo);
        end
    end
endmodule

// File: rtl/fast_seg_detect_chk.sv
module fast_seg_detect_chk
    import fast_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [NPIX*PIX_W-1:0] patch,
    input logic                  corner_valid,
    input logic                  corner_flag,
    input logic [RING_N-1:0]     ring_hi,
    input logic [RING_N-1:0]     ring_lo
);
    logic flat;
    always_comb begin
        flat = 1'b1;
        for (int k = 0; k < RING_N; k++)
            if (patch[ring_index(k)*PIX_W +: PIX_W] != patch[CENTRE_IDX*PIX_W +: PIX_W])
                flat = 1'b0;
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (corner_valid == $past(in_valid)));           // R8
    AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        corner_flag |-> corner_valid);                                // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!corner_valid && !corner_flag));                     // R10
    AST_FLAT_NO_CORNER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && flat) |=> !corner_flag);                         // R11
    AST_POLARITY_EXCL: assert property (@(posedge clk) disable iff (rst)
        (ring_hi & ring_lo) == '0);                                   // R6
endmodule

bind fast_seg_detect fast_seg_detect_chk #(.PIX_W(PIX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .patch       (patch),
    .corner_valid(corner_valid),
    .corner_flag (corner_flag),
    .ring_hi     (ring_hi),
    .ring_lo     (ring_lo)
);

// File: tb/fast_seg_detect_tb.sv
module fast_seg_detect_tb_top;
    localparam int PW = 8;
    localparam int NP = 49;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [NP*PW-1:0] patch = '0;
    logic [PW-1:0] thresh = 8'd1;
    logic          corner_valid;
    logic          corner_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fast_seg_detect dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .patch(patch),
        .thresh(thresh), .corner_valid(corner_valid), .corner_flag(corner_flag)
    );

    // R2 circle order, clockwise from top
    function automatic int ring_pos(input int k);
        int dxs[16] = '{0, 1, 2, 3, 3, 3, 2, 1, 0, -1, -2, -3, -3, -3, -2, -1};
        int dys[16] = '{-3, -3, -2, -1, 0, 1, 2, 3, 3, 3, 2, 1, 0, -1, -2, -3};
        return (3 + dys[k]) * 7 + (3 + dxs[k]);  // R1 row-major
    endfunction

    function automatic bit model(input logic [NP*PW-1:0] p, input logic [PW-1:0] t);
        int c, hl, ll, v;
        bit hi[16];
        bit lo[16];
        bit res;
        c  = int'(p[24*PW +: PW]);
        hl = (c + int'(t) > 255) ? 255 : c + int'(t);   // R3
        ll = (c - int'(t) < 0) ? 0 : c - int'(t);       // R4
        for (int k = 0; k < 16; k++) begin
            v = int'(p[ring_pos(k)*PW +: PW]);
            hi[k] = v > hl;
            lo[k] = v < ll;
        end
        res = 1'b0;
        for (int s = 0; s < 16; s++) begin              // R5 circular runs
            bit ah, al;
            ah = 1'b1; al = 1'b1;
            for (int j = 0; j < 12; j++) begin
                ah &= hi[(s + j) % 16];
                al &= lo[(s + j) % 16];
            end
            res |= ah | al;
        end
        return res;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // apply one patch, check flag one clock later
    task automatic apply(input string req, input logic [NP*PW-1:0] p,
                         input logic [PW-1:0] t, input logic v);
        bit e;
        @(negedge clk);
        patch = p; thresh = t; in_valid = v;
        e = v ? model(p, t) : 1'b0;
        @(posedge clk); #1;
        check({req, " R8 valid"}, corner_valid, v);
        check(req, corner_flag, e);
    endtask

    function automatic logic [NP*PW-1:0] fill(input int c);
        logic [NP*PW-1:0] p;
        for (int i = 0; i < NP; i++) p[i*PW +: PW] = PW'(c);
        return p;
    endfunction

    // run of len at start, brighter (pol=1) or darker, value = centre +/- d
    function automatic logic [NP*PW-1:0] with_run(input int c, input int st,
            input int len, input bit pol, input int d);
        logic [NP*PW-1:0] p;
        int v;
        p = fill(c);
        v = pol ? c + d : c - d;
        if (v > 255) v = 255;
        if (v < 0) v = 0;
        for (int j = 0; j < len; j++) p[ring_pos((st + j) % 16)*PW +: PW] = PW'(v);
        return p;
    endfunction

    initial begin
        logic [NP*PW-1:0] p;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", corner_valid, 1'b0);
        check("R10 reset flag", corner_flag, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R5 / R7: run lengths 10..16 at every start, both polarities
        for (int len = 10; len <= 16; len++)
            for (int st = 0; st < 16; st++) begin
                apply(len >= 12 ? "R5 run" : "R7 short run",
                      with_run(100, st, len, st[0], 20), 8'd1, 1'b1);
            end

        // R3 / R4 strict limits: pixel at exactly centre+t / centre-t
        apply("R3 equal limit", with_run(100, 0, 16, 1'b1, 5), 8'd5, 1'b1);
        apply("R3 above limit", with_run(100, 0, 16, 1'b1, 6), 8'd5, 1'b1);
        apply("R4 equal limit", with_run(100, 3, 16, 1'b0, 5), 8'd5, 1'b1);
        apply("R4 below limit", with_run(100, 3, 16, 1'b0, 6), 8'd5, 1'b1);
        // saturation corners
        apply("R3 centre 255", with_run(255, 0, 16, 1'b1, 0), 8'd0, 1'b1);
        apply("R4 centre 0", with_run(0, 0, 16, 1'b0, 0), 8'd0, 1'b1);
        apply("R3 sat high", with_run(250, 2, 14, 1'b1, 10), 8'd200, 1'b1);
        apply("R4 sat low", with_run(5, 2, 14, 1'b0, 10), 8'd200, 1'b1);
        apply("R4 dark under large thr", with_run(250, 5, 13, 1'b0, 250), 8'd200, 1'b1);

        // R11 flat patch with zero threshold
        apply("R11 flat thr0", fill(77), 8'd0, 1'b1);
        apply("R11 flat thr1", fill(0), 8'd1, 1'b1);

        // R6: mixed run of 6 bright + 6 dark
        p = with_run(100, 0, 6, 1'b1, 30);
        for (int j = 6; j < 12; j++) p[ring_pos(j)*PW +: PW] = 8'd60;
        apply("R6 mixed run", p, 8'd1, 1'b1);

        // R9: strong corner with valid low
        apply("R9 invalid", with_run(100, 0, 16, 1'b1, 50), 8'd1, 1'b0);

        // random patches, some with planted runs
        for (int n = 0; n < 400; n++) begin
            int c, t;
            c = int'($urandom_range(255));
            t = int'($urandom_range(40));
            if (n % 2 == 0) begin
                p = with_run(c, int'($urandom_range(15)), int'($urandom_range(16, 9)),
                             1'($urandom_range(1)), int'($urandom_range(80)));
                for (int i = 0; i < NP; i++)
                    if ($urandom_range(7) == 0) p[i*PW +: PW] = PW'($urandom_range(255));
            end else begin
                for (int i = 0; i < NP; i++) p[i*PW +: PW] = PW'($urandom_range(255));
            end
            apply("R5 random", p, PW'(t), 1'($urandom_range(7) != 0));
        end

        // R10: reset mid-stream
        @(negedge clk);
        patch = with_run(100, 0, 16, 1'b1, 50); in_valid = 1'b1; rst = 1'b1;
        @(posedge clk); #1;
        check("R10 mid reset valid", corner_valid, 1'b0);
        check("R10 mid reset flag", corner_flag, 1'b0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule